// File: doc/BRIEF.md
# NAND Erase and Status Command Front End

This block is the device side of a NAND flash command interface, reduced to the block erase and status read paths. It samples the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins against a core clock. It latches a command or address byte from the 8-bit bus on each rising write strobe. From those cycles it runs the two-step erase handshake, drives a ready/busy pin through a counted stand-in for the erase time, and keeps a status word for the host to poll.

The host puts the device into status output with one command. Every later read cycle returns the status word until a read command switches the output back to the array path. The status word is built combinationally from the live device state, so a host holding the read strobe low sees the ready bit flip at the end of an erase without strobing again. The array is not modelled: the array path returns a fixed fill byte.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset the ready/busy output is 1 (ready), the output path is in array mode (reads return ARRAY_FILL, default 8'hFF) and the result bit is 0.
- R2: Command 8'h60, then two address cycles, then command 8'hD0 drives ready/busy to 0 starting the cycle after the confirm strobe rises, for exactly ERASE_CYCLES clock cycles.
- R3: A pending erase is cancelled by any command other than 8'h60 before the confirm, by 8'hD0 arriving before both address cycles, or by a third address cycle; a later 8'hD0 then starts no erase.
- R4: The status word is {unprotected, ready, 5'b00000, result}: bit 7 is 1 when wp_n is high, bit 6 is 1 when ready and 0 when busy, bits 5..1 are 0.
- R5: Status bit 0 becomes the value of force_fail sampled at the confirm strobe when the erase finishes (0 pass, 1 fail) and holds until the next erase ends.
- R6: If wp_n is low at the confirm strobe, no busy period starts and status bit 0 is 1 from the next cycle.
- R7: Command 8'h70 puts the output path in status mode; it stays there across any number of reads and across every command other than 8'h00 and 8'h50.
- R8: Command 8'h00 or 8'h50 returns the output path to array mode, where reads return ARRAY_FILL.
- R9: With ce_n and re_n held low in status mode, io_out follows the device state (bit 6 goes from 0 to 1 at the end of the erase) with no further strobe edge.
- R10: io_oe is 1 exactly when ce_n and re_n are both low.
- R11: Write strobes with ce_n high are ignored, and an 8'h60 received while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| force_fail | input | 1 | Test input: erase ends with the fail result |
| io_in | input | 8 | Bus byte written by the host |
| io_out | output | 8 | Bus byte driven to the host |
| io_oe | output | 1 | Bus drive enable (tri-state control) |
| rdy_busy_n | output | 1 | Ready (1) or busy (0) |

## Verification
The hardest situation to reach is a status read that spans the end of an erase with the read strobe never released, since a bench that reads with short pulses never sees the live update. The stimulus drops re_n after the confirm, holds it through the whole busy period while counting cycles, and checks io_out on both sides of the transition. Cancellation paths are reached by directed sequences that insert a foreign command, an early confirm and a surplus address cycle, and by a seeded random mix of setup, address, confirm, mode and unrelated commands checked against a bench model of the handshake.

// File: rtl/nand_front_pkg.sv
package nand_front_pkg;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_READ_A      = 8'h00;
  localparam logic [7:0] OP_READ_B      = 8'h50;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ROW_LO,
    SEQ_ROW_HI,
    SEQ_ARMED,
    SEQ_BUSY
  } seq_state_e;

  // Status layout: bit7 unprotected, bit6 ready, bits5..1 zero, bit0 result.
  function automatic logic [7:0] pack_status(input logic fail, input logic ready,
                                             input logic unprot);
    return {unprot, ready, 5'b00000, fail};
  endfunction

  function automatic logic is_read_op(input logic [7:0] op);
    return (op == OP_READ_A) || (op == OP_READ_B);
  endfunction

endpackage

// File: rtl/nand_strobe_sync.sv
module nand_strobe_sync #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic [BUS_W-1:0] io_in,
  output logic             cmd_evt,
  output logic             addr_evt,
  output logic [BUS_W-1:0] bus_byte
);

  logic we_q;
  logic we_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign we_rise  = we_n && !we_q && !ce_n;
  assign cmd_evt  = we_rise && cle && !ale;
  assign addr_evt = we_rise && ale && !cle;
  assign bus_byte = io_in;

  // R11
  no_evt_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !(cmd_evt || addr_evt));

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_front_pkg::*;
#(
  parameter int ERASE_CYCLES = 64,
  parameter int BUS_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_evt,
  input  logic             addr_evt,
  input  logic [BUS_W-1:0] bus_byte,
  input  logic             wp_n,
  input  logic             force_fail,
  output logic             busy,
  output logic             fail
);

  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              fail_q, fail_d;
  logic              pend_q, pend_d;
  logic              confirm_evt;
  logic              cancel_evt;
  logic              pending;

  assign pending     = (state_q == SEQ_ROW_LO) || (state_q == SEQ_ROW_HI) ||
                       (state_q == SEQ_ARMED);
  assign confirm_evt = cmd_evt && (state_q == SEQ_ARMED) && (bus_byte == OP_ERASE_GO);
  assign cancel_evt  = pending &&
                       ((cmd_evt && (bus_byte != OP_ERASE_SETUP) && !confirm_evt) ||
                        (addr_evt && (state_q == SEQ_ARMED)));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fail_d  = fail_q;
    pend_d  = pend_q;
    if (state_q == SEQ_BUSY) begin
      if (cnt_q <= CNT_W'(1)) begin
        state_d = SEQ_IDLE;
        fail_d  = pend_q;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end else if (cmd_evt) begin
      if (bus_byte == OP_ERASE_SETUP) begin
        state_d = SEQ_ROW_LO;
      end else if (confirm_evt) begin
        if (!wp_n) begin
          state_d = SEQ_IDLE;
          fail_d  = 1'b1;
        end else begin
          state_d = SEQ_BUSY;
          cnt_d   = CNT_LOAD;
          pend_d  = force_fail;
        end
      end else begin
        state_d = SEQ_IDLE;
      end
    end else if (addr_evt) begin
      case (state_q)
        SEQ_ROW_LO: state_d = SEQ_ROW_HI;
        SEQ_ROW_HI: state_d = SEQ_ARMED;
        SEQ_ARMED:  state_d = SEQ_IDLE;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      fail_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fail_q  <= fail_d;
      pend_q  <= pend_d;
    end
  end

  assign busy = (state_q == SEQ_BUSY);
  assign fail = fail_q;

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(confirm_evt && wp_n));

  // R3
  cancel_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> !busy);

  // R6
  protected_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (confirm_evt && !wp_n) |=> (!busy && fail));

  // R11
  setup_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q > CNT_W'(1) && cmd_evt) |=> busy);

  // R5
  result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fail));

endmodule

// File: rtl/nand_status_out.sv
module nand_status_out
  import nand_front_pkg::*;
#(
  parameter int              BUS_W      = 8,
  parameter logic [BUS_W-1:0] ARRAY_FILL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_evt,
  input  logic [BUS_W-1:0] bus_byte,
  input  logic             ce_n,
  input  logic             re_n,
  input  logic             busy,
  input  logic             fail,
  input  logic             wp_n,
  output logic [BUS_W-1:0] io_out,
  output logic             io_oe
);

  logic             status_mode_q;
  logic [7:0]       status_word;
  logic [BUS_W-1:0] status_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_mode_q <= 1'b0;
    end else if (cmd_evt) begin
      if (bus_byte == OP_STATUS)       status_mode_q <= 1'b1;
      else if (is_read_op(bus_byte))   status_mode_q <= 1'b0;
    end
  end

  assign status_word = pack_status(fail, !busy, wp_n);

  generate
    if (BUS_W > 8) begin : g_wide
      assign status_bus = {{(BUS_W-8){1'b0}}, status_word};
    end else begin : g_narrow
      assign status_bus = status_word[BUS_W-1:0];
    end
  endgenerate

  assign io_oe  = !ce_n && !re_n;
  assign io_out = status_mode_q ? status_bus : ARRAY_FILL;

  // R4
  stat_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode_q && io_oe) |-> (io_out[5:1] == 5'b00000));

  // R7
  status_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_evt && bus_byte == OP_STATUS) |=> status_mode_q);

  // R8
  array_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_evt && is_read_op(bus_byte)) |=> (io_out == ARRAY_FILL));

  // R9
  live_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode_q && $fell(busy)) |-> io_out[6]);

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front #(
  parameter int         ERASE_CYCLES = 64,
  parameter logic [7:0] ARRAY_FILL   = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic       force_fail,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rdy_busy_n
);

  localparam int BUS_W = 8;

  logic             cmd_evt;
  logic             addr_evt;
  logic [BUS_W-1:0] bus_byte;
  logic             busy;
  logic             fail;

  nand_strobe_sync #(.BUS_W(BUS_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .cle      (cle),
    .ale      (ale),
    .we_n     (we_n),
    .io_in    (io_in),
    .cmd_evt  (cmd_evt),
    .addr_evt (addr_evt),
    .bus_byte (bus_byte)
  );

  nand_erase_seq #(.ERASE_CYCLES(ERASE_CYCLES), .BUS_W(BUS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_evt    (cmd_evt),
    .addr_evt   (addr_evt),
    .bus_byte   (bus_byte),
    .wp_n       (wp_n),
    .force_fail (force_fail),
    .busy       (busy),
    .fail       (fail)
  );

  nand_status_out #(.BUS_W(BUS_W), .ARRAY_FILL(ARRAY_FILL)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_evt  (cmd_evt),
    .bus_byte (bus_byte),
    .ce_n     (ce_n),
    .re_n     (re_n),
    .busy     (busy),
    .fail     (fail),
    .wp_n     (wp_n),
    .io_out   (io_out),
    .io_oe    (io_oe)
  );

  assign rdy_busy_n = !busy;

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || re_n) |-> !io_oe);

endmodule

// File: tb/nand_cmd_front_tb.sv
module nand_cmd_front_tb_top;

  localparam int ERASE_N = 12;

  logic       clk = 1'b0;
  logic       rst_n, ce_n, cle, ale, we_n, re_n, wp_n, force_fail;
  logic [7:0] io_in, io_out;
  logic       io_oe, rdy_busy_n;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  nand_cmd_front #(.ERASE_CYCLES(ERASE_N), .ARRAY_FILL(8'hFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .force_fail(force_fail), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rdy_busy_n(rdy_busy_n)
  );

  function automatic logic [7:0] exp_status(input logic res, input logic bsy, input logic wp);
    logic [7:0] v;
    v = 8'h00;
    if (wp)   v = v | 8'h80;
    if (!bsy) v = v | 8'h40;
    if (res)  v = v | 8'h01;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic wr(input logic c, input logic a, input logic [7:0] d, input logic ce_val);
    @(negedge clk);
    ce_n = ce_val; cle = c; ale = a; io_in = d; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d); wr(1'b1, 1'b0, d, 1'b0); endtask
  task automatic adr(input logic [7:0] d); wr(1'b0, 1'b1, d, 1'b0); endtask

  task automatic rd(output logic [7:0] v, output logic oe);
    @(negedge clk);
    re_n = 1'b0;
    #1 v = io_out; oe = io_oe;
    #1 re_n = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rdy_busy_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic full_erase(input logic ff);
    cmd(8'h60); adr(8'h12); adr(8'h34);
    force_fail = ff;
    cmd(8'hD0);
    force_fail = 1'b0;
  endtask

  logic [7:0] v;
  logic       oe;
  int         n;
  int         phase;
  logic       mode_st;
  logic       res;
  logic [7:0] op;
  logic       ff;

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; cle = 0; ale = 0; we_n = 1; re_n = 1;
    wp_n = 1'b1; force_fail = 1'b0; io_in = 8'h00;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ce_n  = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 ready after reset", rdy_busy_n, 1'b1);
    check("R10 oe idle", io_oe, 1'b0);
    rd(v, oe);
    check("R1 array mode after reset", v, 8'hFF);
    check("R10 oe while reading", oe, 1'b1);

    // R7 status mode, R4 encoding
    cmd(8'h70);
    rd(v, oe);
    check("R4 status idle word", v, exp_status(0, 0, 1));
    rd(v, oe);
    check("R7 status sticky across reads", v, exp_status(0, 0, 1));

    // R2 erase and busy length
    full_erase(1'b0);
    check("R2 busy after confirm", rdy_busy_n, 1'b0);
    wait_ready(n);
    check("R2 busy length", n, ERASE_N);
    rd(v, oe);
    check("R5 pass result", v, exp_status(0, 0, 1));

    // R5 forced fail then pass
    full_erase(1'b1);
    wait_ready(n);
    rd(v, oe);
    check("R5 fail result", v, exp_status(1, 0, 1));
    full_erase(1'b0);
    wait_ready(n);
    rd(v, oe);
    check("R5 pass clears result", v, exp_status(0, 0, 1));

    // R3 cancellations
    cmd(8'h60); adr(8'h01); cmd(8'h70); adr(8'h02); cmd(8'hD0);
    check("R3 foreign command cancels", rdy_busy_n, 1'b1);
    cmd(8'h60); adr(8'h01); cmd(8'hD0);
    check("R3 early confirm cancels", rdy_busy_n, 1'b1);
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'hD0);
    check("R3 extra address cancels", rdy_busy_n, 1'b1);
    cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'h90); cmd(8'hD0);
    check("R3 unrelated command cancels", rdy_busy_n, 1'b1);
    rd(v, oe);
    check("R7 status kept after other commands", v, exp_status(0, 0, 1));

    // R6 write protect
    wp_n = 1'b0;
    full_erase(1'b0);
    check("R6 no busy when protected", rdy_busy_n, 1'b1);
    rd(v, oe);
    check("R6 protected fail word", v, exp_status(1, 0, 0));
    wp_n = 1'b1;
    rd(v, oe);
    check("R4 live protect bit", v, exp_status(1, 0, 1));

    // R9 live update with re_n held low
    full_erase(1'b0);
    @(negedge clk);
    re_n = 1'b0;
    #1 check("R9 busy word while held", io_out, exp_status(1, 1, 1));
    @(negedge clk);
    wait_ready(n);
    #1 check("R9 ready word without toggle", io_out, exp_status(0, 0, 1));
    check("R10 oe held", io_oe, 1'b1);
    re_n = 1'b1;

    // R11 setup ignored while busy; unselected strobes ignored
    full_erase(1'b0);
    cmd(8'h60); adr(8'h05); adr(8'h06);
    wait_ready(n);
    cmd(8'hD0);
    check("R11 setup ignored while busy", rdy_busy_n, 1'b1);
    wr(1, 0, 8'h60, 1'b1); wr(0, 1, 8'h01, 1'b1); wr(0, 1, 8'h02, 1'b1); wr(1, 0, 8'hD0, 1'b1);
    check("R11 unselected strobes ignored", rdy_busy_n, 1'b1);
    wr(1, 0, 8'h00, 1'b1);
    rd(v, oe);
    check("R11 unselected read command ignored", v, exp_status(0, 0, 1));

    // R8 return to array mode
    cmd(8'h00);
    rd(v, oe);
    check("R8 array after 00h", v, 8'hFF);
    cmd(8'h70); cmd(8'h50);
    rd(v, oe);
    check("R8 array after 50h", v, 8'hFF);

    // R10 chip deselected
    @(negedge clk);
    ce_n = 1'b1; re_n = 1'b0;
    #1 check("R10 no drive when deselected", io_oe, 1'b0);
    re_n = 1'b1; ce_n = 1'b0;

    // Random mix against a bench model
    phase = 0; mode_st = 1'b0; res = 1'b0;
    for (int i = 0; i < 80; i++) begin
      case ($urandom_range(0, 5))
        0: op = 8'h60;
        1: op = 8'hAA;
        2: op = 8'hD0;
        3: op = 8'h70;
        4: op = ($urandom_range(0, 1) != 0) ? 8'h00 : 8'h50;
        default: op = 8'h90;
      endcase
      if (op == 8'hAA) begin
        adr(8'(i));
        if (phase == 1) phase = 2;
        else if (phase == 2) phase = 3;
        else if (phase == 3) phase = 0;
        check("R3 random address", rdy_busy_n, 1'b1);
      end else if (op == 8'hD0 && phase == 3) begin
        ff = ($urandom_range(0, 1) != 0);
        force_fail = ff;
        cmd(op);
        force_fail = 1'b0;
        check("R2 random busy", rdy_busy_n, 1'b0);
        wait_ready(n);
        check("R2 random busy length", n, ERASE_N);
        res = ff; phase = 0;
      end else begin
        cmd(op);
        if (op == 8'h60) phase = 1;
        else phase = 0;
        if (op == 8'h70) mode_st = 1'b1;
        if (op == 8'h00 || op == 8'h50) mode_st = 1'b0;
        check("R3 random no busy", rdy_busy_n, 1'b1);
      end
      rd(v, oe);
      check(mode_st ? "R7 random status read" : "R8 random array read",
            v, mode_st ? exp_status(res, 0, 1) : 8'hFF);
    end

    summary();
  end

endmodule